// File: doc/BRIEF.md
# Addressable LED Line Encoder with Shift-Register Readback

The block turns a stream of 24-bit pixel words into the pulse-width coded waveform of a single-wire addressable LED chain. Each bit becomes a fixed-period pulse, and its high time tells the chain whether the bit is a zero or a one. A frame opens with a long low gap and closes with another, so the chain latches what it has received. All durations are given in nanoseconds and are turned into system clock counts.

The same output line also clocks an external 8-bit parallel-in, serial-out shift register. During the opening gap the block pulses an active-low load strobe, so the register captures its parallel inputs. It then releases the strobe well before the first rising edge of the frame. Each of the first eight rising edges of the frame shifts the register by one position. The block samples the register's serial output just ahead of each shift, so every frame returns one byte together with a single-cycle strobe. Later edges of the frame still shift the external register, but the block takes no notice of them.

Top module: `led_strand_encoder`

## Requirements
- R1: Every duration is converted to clock cycles as round(ns * CLK_HZ / 1e9), rounding to the nearest cycle. At the defaults this gives 80/170 cycles for a zero bit, 160/90 cycles for a one bit, and 40 cycles for the load pulse.
- R2: A zero bit drives `led_dout` high for the zero-high count and then low for the zero-low count.
- R3: A one bit drives `led_dout` high for the one-high count and then low for the one-low count.
- R4: Pixel words are taken only in a word-boundary cycle, which is the cycle where `pix_ready` is 1. The block then sends all 24 bits of the word, bit 23 first, with no gap between consecutive words.
- R5: A frame ends when `pix_valid` is 0 in a boundary cycle. `led_dout` then stays low for at least the reset-gap count and idles low afterwards. A frame starts with a low reset gap of the same length.
- R6: `sr_load_n` goes low for the load count at the start of the opening gap and is 1 at every other time. `led_dout` is never high while the load strobe is low. The strobe is released at least the setup count before the first rising edge of the frame.
- R7: `sr_serial_in` is sampled on the clock edge at which `led_dout` goes from 0 to 1, for the first eight such edges of a frame. The first sample lands in bit 7 of `rb_byte`. `rb_strobe` is high for exactly one cycle, and that cycle is the first high cycle of the eighth bit.
- R8: `sr_serial_in` has no effect after the eighth sample of a frame, and `rb_byte` keeps its value between strobes.
- R9: A frame with fewer than eight bits fills the missing low-order bits of `rb_byte` with zeros and still strobes once. For a frame with no words the strobe falls on the last cycle of the opening gap and the byte is 0.
- R10: `frame_start` is ignored while a frame or its closing gap is in progress.
- R11: During reset `led_dout` is 0, `sr_load_n` is 1, `rb_strobe` is 0 and `pix_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_data | input | 24 | Pixel word, bit 23 sent first |
| pix_valid | input | 1 | A pixel word is offered |
| pix_ready | output | 1 | High in a word-boundary cycle; the word is taken if valid |
| frame_start | input | 1 | Request to begin a frame (honoured when idle) |
| led_dout | output | 1 | Encoded LED line, also the external shift clock |
| sr_load_n | output | 1 | Active-low parallel load for the external shift register |
| sr_serial_in | input | 1 | Serial output returned from the external shift register |
| rb_byte | output | 8 | Byte read back during the last frame |
| rb_strobe | output | 1 | One-cycle pulse when `rb_byte` is updated |

## Verification
The hardest situation to reach is the alignment between the sampling edge and the external register's shift, because the register moves on the very edges the block produces. The bench therefore models the external register itself. The model reloads from a chosen byte while the load strobe is low, shifts on every rising line edge it sees, and feeds inverted bits back in after the shift, so a sample taken one edge late or after the eighth edge yields a wrong byte. A frame with no words reaches the padding path, and a start request issued mid-frame exercises the ignore rule.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_BITS,
    ST_POST
  } frame_state_e;

  // nanoseconds to clock cycles, nearest cycle
  function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                               input longint unsigned clk_hz);
    longint unsigned prod;
    prod = ns * clk_hz + 64'd500_000_000;
    return int'(prod / 64'd1_000_000_000);
  endfunction

  // left-align a partial capture of n bits, zero fill below
  function automatic logic [7:0] pad_capture(input logic [7:0] bits,
                                             input logic [3:0] n);
    logic [7:0] r;
    if (n >= 4'd8) r = bits;
    else           r = bits << (4'd8 - n);
    return r;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/led_bit_shaper.sv
module led_bit_shaper #(
  parameter int unsigned H0_CYC = 80,
  parameter int unsigned L0_CYC = 170,
  parameter int unsigned H1_CYC = 160,
  parameter int unsigned L1_CYC = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bit_val,
  output logic line_c,
  output logic bit_first,
  output logic bit_last
);
  localparam int unsigned P0_CYC = H0_CYC + L0_CYC;
  localparam int unsigned P1_CYC = H1_CYC + L1_CYC;
  localparam int unsigned PMAX   = led_enc_pkg::max2(P0_CYC, P1_CYC);
  localparam int unsigned CW     = $clog2(PMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] hi_len;
  logic [CW-1:0] last_idx;

  assign hi_len   = bit_val ? CW'(H1_CYC) : CW'(H0_CYC);
  assign last_idx = bit_val ? CW'(P1_CYC - 1) : CW'(P0_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (!run)            cnt <= '0;
    else if (cnt == last_idx) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign line_c    = run && (cnt < hi_len);
  assign bit_first = run && (cnt == '0);
  assign bit_last  = run && (cnt == last_idx);

endmodule

// File: rtl/led_frame_ctrl.sv
module led_frame_ctrl
  import led_enc_pkg::*;
#(
  parameter int unsigned PIX_W     = 24,
  parameter int unsigned RESET_CYC = 10000,
  parameter int unsigned LOAD_CYC  = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic             bit_last,
  output logic             cur_bit,
  output logic             run,
  output logic             load_c,
  output logic             frame_begin,
  output logic             frame_end
);
  localparam int unsigned GW = $clog2(RESET_CYC + 1);
  localparam int unsigned IW = $clog2(PIX_W);

  frame_state_e     state;
  logic [GW-1:0]    gap_cnt;
  logic [PIX_W-1:0] word;
  logic [IW-1:0]    bit_idx;
  logic             gap_last;
  logic             boundary;

  assign gap_last    = (gap_cnt == GW'(RESET_CYC - 1));
  assign boundary    = ((state == ST_PRE) && gap_last) ||
                       ((state == ST_BITS) && bit_last && (bit_idx == '0));
  assign pix_ready   = boundary;
  assign frame_end   = boundary && !pix_valid;
  assign frame_begin = (state == ST_IDLE) && frame_start;
  assign run         = (state == ST_BITS);
  assign cur_bit     = word[PIX_W-1];
  assign load_c      = (state == ST_PRE) && (gap_cnt < GW'(LOAD_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      gap_cnt <= '0;
      word    <= '0;
      bit_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          gap_cnt <= '0;
          if (frame_start) state <= ST_PRE;
        end
        ST_PRE: begin
          if (gap_last) begin
            gap_cnt <= '0;
            if (pix_valid) begin
              word    <= pix_data;
              bit_idx <= IW'(PIX_W - 1);
              state   <= ST_BITS;
            end else begin
              state <= ST_POST;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (bit_last) begin
            if (bit_idx == '0) begin
              if (pix_valid) begin
                word    <= pix_data;
                bit_idx <= IW'(PIX_W - 1);
              end else begin
                state <= ST_POST;
              end
            end else begin
              word    <= word << 1;
              bit_idx <= bit_idx - 1'b1;
            end
          end
        end
        ST_POST: begin
          if (gap_last) begin
            gap_cnt <= '0;
            state   <= ST_IDLE;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/led_readback_capture.sv
module led_readback_capture
  import led_enc_pkg::*;
#(
  parameter int unsigned CAP_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       rise_evt,
  input  logic       frame_end,
  input  logic       ser_in,
  output logic [7:0] rb_byte,
  output logic       rb_strobe
);
  logic [7:0] shreg;
  logic [3:0] cnt;
  logic       full;

  assign full = (cnt >= 4'(CAP_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      rb_byte   <= '0;
      rb_strobe <= 1'b0;
    end else begin
      rb_strobe <= 1'b0;
      if (clear) begin
        shreg <= '0;
        cnt   <= '0;
      end else if (rise_evt && !full) begin
        shreg <= {shreg[6:0], ser_in};
        cnt   <= cnt + 1'b1;
        if (cnt == 4'(CAP_BITS - 1)) begin
          rb_byte   <= {shreg[6:0], ser_in};
          rb_strobe <= 1'b1;
        end
      end else if (frame_end && !full) begin
        rb_byte   <= pad_capture(shreg, cnt);
        rb_strobe <= 1'b1;
        cnt       <= 4'(CAP_BITS);
      end
    end
  end

endmodule

// File: rtl/led_strand_encoder.sv
module led_strand_encoder #(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned PIX_W    = 24,
  parameter int unsigned T0H_NS   = 400,
  parameter int unsigned T0L_NS   = 850,
  parameter int unsigned T1H_NS   = 800,
  parameter int unsigned T1L_NS   = 450,
  parameter int unsigned RESET_NS = 50000,
  parameter int unsigned LOAD_NS  = 200,
  parameter int unsigned SETUP_NS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic             frame_start,
  output logic             led_dout,
  output logic             sr_load_n,
  input  logic             sr_serial_in,
  output logic [7:0]       rb_byte,
  output logic             rb_strobe
);
  localparam int unsigned H0_CYC    = led_enc_pkg::ns_to_cycles(T0H_NS, CLK_HZ);
  localparam int unsigned L0_CYC    = led_enc_pkg::ns_to_cycles(T0L_NS, CLK_HZ);
  localparam int unsigned H1_CYC    = led_enc_pkg::ns_to_cycles(T1H_NS, CLK_HZ);
  localparam int unsigned L1_CYC    = led_enc_pkg::ns_to_cycles(T1L_NS, CLK_HZ);
  localparam int unsigned RESET_CYC = led_enc_pkg::ns_to_cycles(RESET_NS, CLK_HZ);
  localparam int unsigned LOAD_CYC  = led_enc_pkg::ns_to_cycles(LOAD_NS, CLK_HZ);
  localparam int unsigned SETUP_CYC = led_enc_pkg::ns_to_cycles(SETUP_NS, CLK_HZ);
  localparam int unsigned P0_CYC    = H0_CYC + L0_CYC;
  localparam int unsigned P1_CYC    = H1_CYC + L1_CYC;

  // named internal events
  logic line_c;
  logic load_c;
  logic run;
  logic cur_bit;
  logic rise_evt;
  logic bit_last_evt;
  logic frame_begin_evt;
  logic frame_end_evt;

  led_frame_ctrl #(
    .PIX_W    (PIX_W),
    .RESET_CYC(RESET_CYC),
    .LOAD_CYC (LOAD_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .pix_data   (pix_data),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .bit_last   (bit_last_evt),
    .cur_bit    (cur_bit),
    .run        (run),
    .load_c     (load_c),
    .frame_begin(frame_begin_evt),
    .frame_end  (frame_end_evt)
  );

  led_bit_shaper #(
    .H0_CYC(H0_CYC),
    .L0_CYC(L0_CYC),
    .H1_CYC(H1_CYC),
    .L1_CYC(L1_CYC)
  ) u_shaper (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .bit_val  (cur_bit),
    .line_c   (line_c),
    .bit_first(rise_evt),
    .bit_last (bit_last_evt)
  );

  led_readback_capture #(
    .CAP_BITS(8)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (frame_begin_evt),
    .rise_evt (rise_evt),
    .frame_end(frame_end_evt),
    .ser_in   (sr_serial_in),
    .rb_byte  (rb_byte),
    .rb_strobe(rb_strobe)
  );

  // output stage: line and load leave through flops
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_dout  <= 1'b0;
      sr_load_n <= 1'b1;
    end else begin
      led_dout  <= line_c;
      sr_load_n <= !load_c;
    end
  end

endmodule

// File: rtl/led_strand_encoder_chk.sv
module led_strand_encoder_chk #(
  parameter int unsigned H0_CYC    = 80,
  parameter int unsigned H1_CYC    = 160,
  parameter int unsigned P0_CYC    = 250,
  parameter int unsigned P1_CYC    = 250,
  parameter int unsigned RESET_CYC = 10000,
  parameter int unsigned SETUP_CYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic led_dout,
  input logic sr_load_n,
  input logic rb_strobe,
  input logic pix_ready,
  input logic rise_evt
);
  localparam int unsigned SAT = 32'h4000_0000;

  logic        dout_d;
  logic        load_d;
  int unsigned high_cnt;
  int unsigned since_rise;
  logic        rise_seen;
  int unsigned rel_cnt;
  logic        rel_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_d     <= 1'b0;
      load_d     <= 1'b1;
      high_cnt   <= 0;
      since_rise <= 0;
      rise_seen  <= 1'b0;
      rel_cnt    <= 0;
      rel_seen   <= 1'b0;
    end else begin
      dout_d   <= led_dout;
      load_d   <= sr_load_n;
      high_cnt <= led_dout ? ((high_cnt < SAT) ? high_cnt + 1 : high_cnt) : 0;
      if (led_dout && !dout_d) begin
        since_rise <= 1;
        rise_seen  <= 1'b1;
      end else if (since_rise < SAT) begin
        since_rise <= since_rise + 1;
      end
      if (sr_load_n && !load_d) begin
        rel_cnt  <= 1;
        rel_seen <= 1'b1;
      end else if (rel_cnt < SAT) begin
        rel_cnt <= rel_cnt + 1;
      end
    end
  end

  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(led_dout) |-> (high_cnt == H0_CYC || high_cnt == H1_CYC)); // R2
  AST_RISE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(led_dout) && rise_seen) |->
      (since_rise == P0_CYC || since_rise == P1_CYC || since_rise > RESET_CYC)); // R5
  AST_LOAD_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led_dout) |-> (rel_seen && rel_cnt >= SETUP_CYC)); // R6
  AST_LOAD_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_load_n |-> !led_dout); // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rb_strobe |=> !rb_strobe); // R7
  AST_RISE_REACHES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> led_dout); // R7
  AST_READY_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> !led_dout); // R4

endmodule

bind led_strand_encoder led_strand_encoder_chk #(
  .H0_CYC   (H0_CYC),
  .H1_CYC   (H1_CYC),
  .P0_CYC   (P0_CYC),
  .P1_CYC   (P1_CYC),
  .RESET_CYC(RESET_CYC),
  .SETUP_CYC(SETUP_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .led_dout (led_dout),
  .sr_load_n(sr_load_n),
  .rb_strobe(rb_strobe),
  .pix_ready(pix_ready),
  .rise_evt (rise_evt)
);

// File: tb/sim_led_strand_encoder.sv
`timescale 1ns/1ps
module sim_led_strand_encoder;
  localparam int CLK_HZ   = 200_000_000;
  localparam int RESET_NS = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pix_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic        frame_start = 1'b0;
  logic        led_dout;
  logic        sr_load_n;
  logic        sr_serial_in = 1'b0;
  logic [7:0]  rb_byte;
  logic        rb_strobe;

  led_strand_encoder #(.CLK_HZ(CLK_HZ), .RESET_NS(RESET_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .frame_start(frame_start), .led_dout(led_dout),
    .sr_load_n(sr_load_n), .sr_serial_in(sr_serial_in), .rb_byte(rb_byte),
    .rb_strobe(rb_strobe));

  always #2.5 clk = ~clk;

  // R1: bench's own rounding of durations
  function automatic int to_cyc(input real ns);
    return $rtoi(ns * CLK_HZ / 1.0e9 + 0.5);
  endfunction
  int h0, l0, h1, l1, gap_c, load_c;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit          exp_line[$];
  bit          exp_load[$];
  bit          exp_stb[$];
  logic [7:0]  exp_byte[$];
  logic [23:0] pixq[$];
  logic [7:0]  par_val = 8'h00;
  logic [7:0]  sr = 8'h00;
  bit          prev_dout = 1'b0;
  int          takes = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
    end
  endtask

  // per-cycle comparison and external shift register model
  always @(negedge clk) begin
    if (rst_n) begin
      bit el, ld, es;
      el = 1'b0; ld = 1'b1; es = 1'b0;
      if (exp_line.size() > 0) begin
        el = exp_line.pop_front();
        ld = exp_load.pop_front();
        es = exp_stb.pop_front();
      end
      check(led_dout === el, "R1 R2 R3 R4 R5", "line", led_dout, el);
      check(sr_load_n === ld, "R6", "load_n", sr_load_n, ld);
      check(rb_strobe === es, "R7 R9", "strobe", rb_strobe, es);
      if (es && rb_strobe && exp_byte.size() > 0) begin
        logic [7:0] eb;
        eb = exp_byte.pop_front();
        check(rb_byte === eb, "R7 R8 R9", "byte", rb_byte, eb);
      end
    end
    if (!sr_load_n) sr = par_val;
    else if (led_dout && !prev_dout) sr = {sr[6:0], ~sr[7]};
    prev_dout    = led_dout;
    sr_serial_in = sr[7];
  end

  // pixel source
  always begin
    bit took;
    @(negedge clk);
    took = pix_ready && pix_valid;
    @(posedge clk);
    #2;
    if (took) begin
      void'(pixq.pop_front());
      takes++;
    end
    pix_valid = (pixq.size() > 0);
    pix_data  = (pixq.size() > 0) ? pixq[0] : 24'h0;
  end

  task automatic push_cyc(input bit l, input bit ld, input bit s);
    exp_line.push_back(l); exp_load.push_back(ld); exp_stb.push_back(s);
  endtask

  task automatic run_frame(input logic [23:0] w[$], input logic [7:0] par, input int poke);
    int nbits;
    @(posedge clk); #1;
    par_val = par;
    takes = 0;
    foreach (w[k]) pixq.push_back(w[k]);
    push_cyc(0, 1, 0);
    push_cyc(0, 1, 0);
    for (int i = 0; i < gap_c; i++)
      push_cyc(0, (i < load_c) ? 1'b0 : 1'b1, (w.size() == 0 && i == gap_c - 1));
    nbits = 0;
    foreach (w[k]) begin
      for (int b = 23; b >= 0; b--) begin
        int hi, lo;
        hi = w[k][b] ? h1 : h0;
        lo = w[k][b] ? l1 : l0;
        for (int c = 0; c < hi; c++) push_cyc(1, 1, (nbits == 7 && c == 0));
        for (int c = 0; c < lo; c++) push_cyc(0, 1, 0);
        nbits++;
      end
    end
    for (int i = 0; i < gap_c; i++) push_cyc(0, 1, 0);
    exp_byte.push_back((w.size() == 0) ? 8'h00 : par);
    frame_start = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
    if (poke > 0) begin
      // R10: request during a running frame must change nothing
      repeat (poke) @(posedge clk);
      #1 frame_start = 1'b1;
      @(posedge clk); #1 frame_start = 1'b0;
    end
    while (exp_line.size() > 0) @(negedge clk);
    check(pixq.size() == 0, "R4", "words left", pixq.size(), 0);
    check(takes == w.size(), "R4", "words taken", takes, w.size());
    check(exp_byte.size() == 0, "R7 R9", "strobes missing", exp_byte.size(), 0);
  endtask

  initial begin
    logic [23:0] w[$];
    h0 = to_cyc(400); l0 = to_cyc(850); h1 = to_cyc(800); l1 = to_cyc(450);
    gap_c = to_cyc(RESET_NS); load_c = to_cyc(200);
    repeat (5) @(negedge clk);
    // R11: reset state
    check(led_dout === 1'b0, "R11", "line in reset", led_dout, 0);
    check(sr_load_n === 1'b1, "R11", "load_n in reset", sr_load_n, 1);
    check(rb_strobe === 1'b0, "R11", "strobe in reset", rb_strobe, 0);
    check(pix_ready === 1'b0, "R11", "ready in reset", pix_ready, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (20) @(negedge clk);

    w = '{24'hA50F3C};                run_frame(w, 8'hB4, 0);
    w = '{24'hFF0000, 24'h00FF81};    run_frame(w, 8'h5A, 3000);
    w = '{};                          run_frame(w, 8'h77, 0);
    w = '{24'h000001};                run_frame(w, 8'hFF, 0);
    w = '{24'h123456, 24'h789ABC, 24'hFFFFFF}; run_frame(w, 8'h01, 100);

    // R10: line stays idle after the ignored requests
    for (int i = 0; i < 2 * gap_c; i++) begin
      @(negedge clk);
      check(led_dout === 1'b0, "R10", "idle line", led_dout, 0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule